// File: doc/BRIEF.md
# Multi-Register Memory Transfer Sequencer

This block carries out the "move many registers" instruction of a CPU that has eight data registers and eight address registers. On `start` it takes the instruction word, a 16-bit register selection mask and a start address. An effective-address unit outside the block has already produced that address. For register-indirect, post-increment and pre-decrement modes the start address is the current contents of the base address register. The block then runs one memory access per selected register over a request/acknowledge port. It reads or writes the register file through its own ports. Where the mode needs it, it writes the updated address back into the base register.

Register file index 0..7 is D0..D7 and index 8..15 is A0..A7. The instruction word fields used are bit 10 (direction), bit 6 (size), bits 5:3 (addressing mode) and bits 2:0 (base address register number n, meaning register file index 8+n). Loads go into a holding buffer first. The register file is touched only once every read has been acknowledged. The only error the block reports is an illegal addressing mode.

Top module: `mrx_seq`

## Requirements
- R1: Instruction bit 10 = 1 moves memory into registers (`mem_we` = 0); bit 10 = 0 moves registers into memory (`mem_we` = 1).
- R2: Instruction bit 6 = 1 transfers 32-bit words with an address step of 4 and `mem_size` = 1. Bit 6 = 0 transfers 16-bit words with a step of 2 and `mem_size` = 0; for 16-bit stores only `mem_wdata[15:0]` carries the value.
- R3: Outside pre-decrement mode, mask bit i selects register file index i. Selected registers are moved lowest index first, at addresses base, base+step, base+2*step and so on.
- R4: Mode 0 and mode 1 (bits 5:3) fault. `done` and `addr_fault` rise together one cycle after `start`, with no memory request and no register write.
- R5: Mode 3 is legal only for loads, and a store in mode 3 faults as in R4. After a mode-3 load, register 8+n holds base + count*step, written after all loaded registers.
- R6: Mode 4 is legal only for stores, and a load in mode 4 faults as in R4. Mask bit k selects register index 15-k, and bit 0 is handled first. Each store goes to the current address minus step. Register 8+n finally holds base - count*step.
- R7: In mode 4, when register 8+n is itself stored and `enhanced` = 1, the stored value is base - step. With `enhanced` = 0 it is the register's unchanged value.
- R8: For loads, no register write happens until the last read has been acknowledged. The loaded registers then take the read values.
- R9: On 16-bit loads, `mem_rdata[15:0]` is sign-extended to 32 bits before it is written.
- R10: With an all-zero mask, `done` rises one cycle after `start` with no memory access. In modes 3 and 4 register 8+n is rewritten with its unchanged value.
- R11: `done` is high for exactly one cycle per instruction and `busy` is low again after it. A `start` while `busy` is ignored.
- R12: Modes 2, 5, 6 and 7 move data in ascending order from the given address and leave every address register unchanged, except those loaded.
- R13: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_size` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 16 | Instruction word |
| reg_mask | input | 16 | Register selection mask |
| base_addr | input | 32 | Start address / base register contents |
| enhanced | input | 1 | Selects the decremented self-store value in mode 4 |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| addr_fault | output | 1 | Illegal addressing mode, valid with `done` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = 32-bit, 0 = 16-bit access |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |

## Verification
The stimulus targets the pre-decrement path with the base register inside the mask, under both settings of `enhanced`. A design that picks the wrong self-store value writes the base itself, or an address from midway through the loop, to memory. It also checks that the mask order is reversed; a design that forgets the reversal stores D0 where A7 belongs. Word loads are aimed at values with bit 15 set, and those come back zero-extended when the sign extension is missing. Loads whose mask includes the base register in mode 3 catch a design that writes registers before the reads finish, or lets a loaded value win over the final address.

// File: rtl/mrx_pkg.sv
// Package: shared state and control types of the multi-register transfer sequencer.
// Assumes a 16-entry register file: D0..D7 at index 0..7, A0..A7 at 8..15.
package mrx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FIN   = 2'd3
    } mrx_state_t;

    // Decoded, latched view of the instruction word.
    typedef struct packed {
        logic       load;
        logic       is_long;
        logic       predec;
        logic       wback;
        logic       fault;
        logic [2:0] breg;
    } mrx_ctl_t;

    localparam logic [2:0] EA_DREG    = 3'd0;
    localparam logic [2:0] EA_AREG    = 3'd1;
    localparam logic [2:0] EA_POSTINC = 3'd3;
    localparam logic [2:0] EA_PREDEC  = 3'd4;

endpackage

// File: rtl/mrx_decode.sv
// Module: mrx_decode
// Turns the instruction word into direction, size, fault and write-back controls.
// Assumes only bits 10, 6, 5:3 and 2:0 carry meaning for this block.
module mrx_decode
    import mrx_pkg::*;
(
    input  logic [15:0] opcode,
    output mrx_ctl_t    ctl
);

    logic [2:0] mode;
    logic       ld;
    logic       bad;
    logic       unused_opcode_bits;

    assign unused_opcode_bits = ^{opcode[15:11], opcode[9:7]};

    // Field extraction and legality rules for the addressing mode.
    always_comb begin
        mode = opcode[5:3];
        ld   = opcode[10];
        bad  = (mode == EA_DREG) || (mode == EA_AREG) ||
               ((mode == EA_POSTINC) && !ld) || ((mode == EA_PREDEC) && ld);
        ctl.load    = ld;
        ctl.is_long = opcode[6];
        ctl.breg    = opcode[2:0];
        ctl.fault   = bad;
        ctl.wback   = !bad && ((mode == EA_POSTINC) || (mode == EA_PREDEC));
        ctl.predec  = !bad && (mode == EA_PREDEC);
    end

endmodule

// File: rtl/mrx_picker.sv
// Module: mrx_picker
// Finds the lowest set bit of a pending mask and gives its index and one-hot form.
// Assumes N is a power of two.
module mrx_picker #(
    parameter int N = 16
) (
    input  logic [N-1:0]         pool,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx,
    output logic [N-1:0]         onehot
);

    localparam int IW = $clog2(N);

    // Priority scan, lowest index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pool[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        onehot = found ? (N'(1) << idx) : '0;
    end

endmodule

// File: rtl/mrx_holdbuf.sv
// Module: mrx_holdbuf
// Holding buffer for load data, one entry per register file index.
// Assumes contents need no reset: an entry is always written before it is read.
module mrx_holdbuf #(
    parameter int N = 16,
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [W-1:0]         wr_data,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic [W-1:0]         rd_data
);

    localparam int IW = $clog2(N);

    logic [N-1:0][W-1:0] ent;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [W-1:0] ent_q;
        // Capture read data into this entry when it is the target.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IW'(g))) begin
                ent_q <= wr_data;
            end
        end
        assign ent[g] = ent_q;
    end

    assign rd_data = ent[rd_idx];

endmodule

// File: rtl/mrx_seq.sv
// Module: mrx_seq (top)
// Runs a multiple-register move: one memory access per selected register,
// buffered loads, mode-dependent ordering and base register write-back.
// Assumes rf_rdata is a combinational read of rf_raddr, and base_addr holds the
// base register contents in modes 2, 3 and 4.
module mrx_seq
    import mrx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NREG   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [15:0]               opcode,
    input  logic [NREG-1:0]           reg_mask,
    input  logic [ADDR_W-1:0]         base_addr,
    input  logic                      enhanced,
    output logic                      busy,
    output logic                      done,
    output logic                      addr_fault,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic                      mem_size,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic                      mem_ack,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic [$clog2(NREG)-1:0]   rf_raddr,
    input  logic [DATA_W-1:0]         rf_rdata,
    output logic                      rf_we,
    output logic [$clog2(NREG)-1:0]   rf_waddr,
    output logic [DATA_W-1:0]         rf_wdata
);

    localparam int IW      = $clog2(NREG);
    localparam int HALF    = NREG / 2;
    localparam int WORD_W  = DATA_W / 2;
    localparam int BYTES_L = DATA_W / 8;
    localparam int BYTES_W = WORD_W / 8;

    mrx_state_t        state_q;
    mrx_ctl_t          ctl_q;
    mrx_ctl_t          dec;
    logic [NREG-1:0]   rem_q;
    logic [NREG-1:0]   mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base_q;
    logic              enh_q;

    logic              pick_any;
    logic [IW-1:0]     pick_idx;
    logic [NREG-1:0]   pick_oh;
    logic [NREG-1:0]   rem_left;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] addr_next;
    logic [IW-1:0]     reg_idx;
    logic [IW-1:0]     base_idx;
    logic              self_hit;
    logic [DATA_W-1:0] ld_data;
    logic [DATA_W-1:0] buf_rd;
    logic              buf_wr;

    mrx_decode u_decode (
        .opcode (opcode),
        .ctl    (dec)
    );

    mrx_picker #(.N(NREG)) u_picker (
        .pool   (rem_q),
        .found  (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    mrx_holdbuf #(.N(NREG), .W(DATA_W)) u_holdbuf (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_idx  (reg_idx),
        .wr_data (ld_data),
        .rd_idx  (pick_idx),
        .rd_data (buf_rd)
    );

    // Address step, next address and register index for the current slot.
    always_comb begin
        step      = ctl_q.is_long ? ADDR_W'(BYTES_L) : ADDR_W'(BYTES_W);
        addr_next = ctl_q.predec ? (addr_q - step) : (addr_q + step);
        rem_left  = rem_q & ~pick_oh;
        reg_idx   = ctl_q.predec ? (IW'(NREG - 1) - pick_idx) : pick_idx;
        base_idx  = IW'(HALF) + IW'(ctl_q.breg);
        self_hit  = ctl_q.predec && enh_q && (reg_idx == base_idx);
        ld_data   = ctl_q.is_long ? mem_rdata
                                  : {{(DATA_W - WORD_W){mem_rdata[WORD_W-1]}}, mem_rdata[WORD_W-1:0]};
        buf_wr    = (state_q == ST_XFER) && mem_ack && ctl_q.load;
    end

    // Memory port: pre-decrement addresses the slot below the current pointer.
    always_comb begin
        mem_req   = (state_q == ST_XFER);
        mem_we    = !ctl_q.load;
        mem_size  = ctl_q.is_long;
        mem_addr  = ctl_q.predec ? (addr_q - step) : addr_q;
        rf_raddr  = reg_idx;
        mem_wdata = self_hit ? DATA_W'(base_q - step) : rf_rdata;
    end

    // Register file write port: drain the buffer, then write back the base.
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = pick_idx;
        rf_wdata = buf_rd;
        if (state_q == ST_DRAIN) begin
            rf_we = pick_any;
        end else if (state_q == ST_FIN) begin
            rf_we    = ctl_q.wback;
            rf_waddr = base_idx;
            rf_wdata = DATA_W'(addr_q);
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_FIN);
    assign addr_fault = (state_q == ST_FIN) && ctl_q.fault;

    // Sequencer state, pending mask and address pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            rem_q   <= '0;
            mask_q  <= '0;
            addr_q  <= '0;
            base_q  <= '0;
            enh_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctl_q   <= dec;
                        rem_q   <= dec.fault ? '0 : reg_mask;
                        mask_q  <= reg_mask;
                        addr_q  <= base_addr;
                        base_q  <= base_addr;
                        enh_q   <= enhanced;
                        state_q <= (dec.fault || (reg_mask == '0)) ? ST_FIN : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (mem_ack) begin
                        addr_q <= addr_next;
                        rem_q  <= rem_left;
                        if (rem_left == '0) begin
                            if (ctl_q.load) begin
                                rem_q   <= mask_q;
                                state_q <= ST_DRAIN;
                            end else begin
                                state_q <= ST_FIN;
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    rem_q <= rem_left;
                    if (rem_left == '0) begin
                        state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R13: request held with stable attributes until acknowledged.
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

    // R8: no register write while a read is outstanding.
    a_r8_no_write_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !rf_we);

    // R11: completion is a single-cycle pulse.
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: register-direct modes fault on the next cycle.
    a_r4_fault_next: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (opcode[5:4] == 2'b00)) |=> (done && addr_fault));

    // R4: a faulting instruction neither accesses memory nor writes registers.
    a_r4_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        addr_fault |-> (!mem_req && !rf_we));

    // R10: empty mask completes on the next cycle.
    a_r10_empty_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (reg_mask == '0)) |=> done);

endmodule

// File: tb/test_mrx_seq.sv
// Bench for mrx_seq: directed corner cases plus seeded random instructions,
// checked against a model computed from the requirements.
module test_mrx_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] reg_mask = '0;
    logic [31:0] base_addr = '0;
    logic        enhanced = 1'b0;
    logic        busy, done, addr_fault;
    logic        mem_req, mem_we, mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;

    logic [31:0] rf_m [16];
    logic [31:0] lg_addr [16];
    logic [31:0] lg_data [16];
    logic        lg_we [16];
    logic        lg_size [16];
    int          lg_n = 0;
    int          first_we = -1;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc_total = 0;

    always #10 clk = ~clk;  // 50 MHz

    assign rf_rdata = rf_m[rf_raddr];

    mrx_seq i_mrx_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .reg_mask(reg_mask),
        .base_addr(base_addr), .enhanced(enhanced), .busy(busy), .done(done),
        .addr_fault(addr_fault), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata)
    );

    function automatic logic [31:0] mfun(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h6D2B_79F5;
    endfunction

    function automatic logic [31:0] sext16(input logic [31:0] v);
        return {{16{v[15]}}, v[15:0]};
    endfunction

    // Memory responder: random acknowledge delay, data from address.
    always @(negedge clk) begin
        mem_ack   = rst_n && mem_req && (($urandom % 4) != 0);
        mem_rdata = mfun(mem_addr);
    end

    // Register file model and access log.
    always @(posedge clk) begin
        cyc_total++;
        if (rst_n) begin
            if (rf_we) begin
                if (first_we < 0) first_we = lg_n;
                rf_m[rf_waddr] = rf_wdata;
            end
            if (mem_req && mem_ack && lg_n < 16) begin
                lg_addr[lg_n] = mem_addr;
                lg_data[lg_n] = mem_wdata;
                lg_we[lg_n]   = mem_we;
                lg_size[lg_n] = mem_size;
                lg_n++;
            end
        end
        if (cyc_total > 190000) begin
            n_fail++;
            $display("FAIL R11 watchdog expired: actual %0d cycles expected fewer", cyc_total);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input bit ld, input bit lg, input logic [2:0] md, input logic [2:0] br,
                          input logic [15:0] mk, input logic [31:0] base, input bit enh,
                          input bit poke, input string xtag);
        logic [31:0] init_rf [16];
        logic [31:0] exp_rf [16];
        logic [31:0] e_addr [16];
        logic [31:0] e_data [16];
        logic [31:0] step, a, v;
        int n, ri, cyc, bi;
        bit flt;
        string tag;
        step = lg ? 32'd4 : 32'd2;
        bi   = 8 + int'(br);
        flt  = (md <= 3'd1) || (md == 3'd3 && !ld) || (md == 3'd4 && ld);
        if (md <= 3'd1)      tag = "R4";
        else if (md == 3'd3) tag = "R5";
        else if (md == 3'd4) tag = "R6";
        else if (md == 3'd2) tag = "R3";
        else                 tag = "R12";
        tag = {tag, xtag};
        @(negedge clk);
        for (int r = 0; r < 16; r++) init_rf[r] = $urandom;
        if (md >= 3'd2 && md <= 3'd4) init_rf[bi] = base;
        for (int r = 0; r < 16; r++) begin
            rf_m[r]   = init_rf[r];
            exp_rf[r] = init_rf[r];
        end
        n = 0;
        a = base;
        if (!flt) begin
            for (int k = 0; k < 16; k++) begin
                if (mk[k]) begin
                    ri = (md == 3'd4) ? 15 - k : k;
                    if (md == 3'd4) a = a - step;
                    e_addr[n] = a;
                    if (ld) begin
                        v = mfun(a);
                        exp_rf[ri] = lg ? v : sext16(v);
                    end else begin
                        e_data[n] = (md == 3'd4 && enh && ri == bi) ? base - step : init_rf[ri];
                    end
                    if (md != 3'd4) a = a + step;
                    n++;
                end
            end
            if (md == 3'd3 || md == 3'd4) exp_rf[bi] = a;
        end
        opcode    = 16'h4880 | (16'(ld) << 10) | (16'(lg) << 6) | (16'(md) << 3) | 16'(br);
        reg_mask  = mk;
        base_addr = base;
        enhanced  = enh;
        start     = 1'b1;
        lg_n      = 0;
        first_we  = -1;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 2) begin
                start    = 1'b1;  // R11: must be ignored while busy
                opcode   = 16'h4C00;
                reg_mask = 16'h0001;
                base_addr = 32'h0;
            end
            if (poke && cyc == 3) start = 1'b0;
        end
        chk(done, tag, "done seen", 32'(done), 32'd1);
        chk(addr_fault == flt, tag, "addr_fault", 32'(addr_fault), 32'(flt));
        if (flt || mk == 16'h0)
            chk(cyc == 1, flt ? "R4" : "R10", "cycles to done", cyc, 1);
        @(negedge clk);
        chk(!done && !busy, "R11", "done/busy after completion", {30'd0, done, busy}, 32'd0);
        chk(lg_n == n, tag, "access count", lg_n, n);
        for (int j = 0; j < n && j < lg_n; j++) begin
            chk(lg_addr[j] == e_addr[j], tag, "access address", lg_addr[j], e_addr[j]);
            chk(lg_we[j] == !ld, "R1", "access direction", 32'(lg_we[j]), 32'(!ld));
            chk(lg_size[j] == lg, "R2", "access size", 32'(lg_size[j]), 32'(lg));
            if (!ld) begin
                if (lg) chk(lg_data[j] == e_data[j], {tag, "/R7"}, "store data", lg_data[j], e_data[j]);
                else    chk(lg_data[j][15:0] == e_data[j][15:0], {tag, "/R2"}, "word store data",
                            {16'd0, lg_data[j][15:0]}, {16'd0, e_data[j][15:0]});
            end
        end
        if (ld && n > 0)
            chk(first_we == n, "R8", "reads done before first register write", first_we, n);
        for (int r = 0; r < 16; r++)
            chk(rf_m[r] === exp_rf[r], tag, $sformatf("register %0d", r), rf_m[r], exp_rf[r]);
    endtask

    initial begin
        logic [31:0] sb, seed_sink;
        seed_sink = $urandom(32'd24680);
        for (int r = 0; r < 16; r++) rf_m[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(!busy && !done && !mem_req && !rf_we && !addr_fault, "R11", "reset outputs",
            {27'd0, busy, done, mem_req, rf_we, addr_fault}, 32'd0);

        // R4 register-direct modes, R5/R6 wrong-direction combinations
        run_op(1, 1, 3'd0, 3'd2, 16'h00FF, 32'h0000_2000, 0, 0, "");
        run_op(0, 0, 3'd1, 3'd5, 16'hFFFF, 32'h0000_2000, 0, 0, "");
        run_op(0, 1, 3'd3, 3'd1, 16'h0F0F, 32'h0000_3000, 0, 0, "");
        run_op(1, 1, 3'd4, 3'd6, 16'hF0F0, 32'h0000_3000, 1, 0, "");
        // R3 indirect long load, R1 direction
        run_op(1, 1, 3'd2, 3'd0, 16'h8001, 32'h0000_4000, 0, 0, "/R1");
        // R5 post-increment load that includes its own base register (A4)
        run_op(1, 1, 3'd3, 3'd4, 16'h1F03, 32'h0000_5000, 0, 0, "");
        // R6/R7 pre-decrement stores of all registers, base A3, both settings
        run_op(0, 1, 3'd4, 3'd3, 16'hFFFF, 32'h0000_6000, 1, 0, "/R7");
        run_op(0, 1, 3'd4, 3'd3, 16'hFFFF, 32'h0000_6000, 0, 0, "/R7");
        run_op(0, 0, 3'd4, 3'd7, 16'h0181, 32'h0000_6100, 1, 0, "/R2");
        // R10 empty mask in modes 3, 4 and 2
        run_op(1, 1, 3'd3, 3'd2, 16'h0000, 32'h0000_7000, 0, 0, "/R10");
        run_op(0, 0, 3'd4, 3'd5, 16'h0000, 32'h0000_7100, 1, 0, "/R10");
        run_op(1, 0, 3'd2, 3'd1, 16'h0000, 32'h0000_7200, 0, 0, "/R10");
        // R12 other modes
        run_op(0, 1, 3'd5, 3'd6, 16'hC3C3, 32'h0000_8000, 1, 0, "");
        run_op(1, 0, 3'd7, 3'd0, 16'h3C00, 32'h0000_8800, 0, 0, "");
        // R9 word load at addresses whose low half has bit 15 set
        sb = 32'h0000_9000;
        while (!(mfun(sb)[15] && mfun(sb + 2)[15])) sb = sb + 4;
        run_op(1, 0, 3'd2, 3'd2, 16'h0003, sb, 0, 0, "/R9");
        // R11 start pulse while busy
        run_op(0, 1, 3'd2, 3'd1, 16'hFFFF, 32'h0000_A000, 0, 1, "/R11");

        // Random instructions over legal modes
        for (int t = 0; t < 60; t++) begin
            logic [2:0] md;
            bit ld;
            md = 3'(2 + ($urandom % 6));
            ld = (md == 3'd3) ? 1'b1 : (md == 3'd4) ? 1'b0 : 1'($urandom % 2);
            run_op(ld, 1'($urandom % 2), md, 3'($urandom % 8), 16'($urandom),
                   32'h0001_0000 + (($urandom % 4096) << 2), 1'($urandom % 2), 0, "/R9");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule